// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Events

This block sits between a simple register bus and a small group of general-purpose pins. The pins are divided into a low bank and a high bank, and the split point is a parameter. Each bank has eight word-aligned registers:

- pin enable
- direction
- output/readback level
- rising-edge arm
- falling-edge arm
- event mask
- a spare routing word that is only stored
- sticky edge status

Pad inputs pass through a two-flop synchronizer. Edges are then detected against the previous sample and latched into status. The OR of every unmasked status bit in both banks drives one level-sensitive event line. Software clears that line by writing ones to the status bits.

Each pin's output enable and output value come straight from the bank registers. Reads are combinational from the address. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, every direction bit reads 1 (input) and every other register reads 0. `pin_oe` is all zero and `event_out` is low.
- R2: `bus_addr[5]` selects the bank: 0 is low, 1 is high. `bus_addr[4:2]` selects the register: 0 enable, 1 direction, 2 level, 3 rising arm, 4 falling arm, 5 event mask, 6 route, 7 status. Pin p below RESUME_BASE is bit p of the low bank. Any other pin is bit (p - RESUME_BASE) of the high bank.
- R3: `bus_wstrb[k]` gates write data bits [8k+7:8k]. Bytes whose strobe is 0 keep their value. Register bits above the bank's pin count read 0.
- R4: `pin_oe[p]` equals enable AND NOT direction for that pin. `pin_out[p]` equals the stored level bit.
- R5: A write to the level bit of a pin whose direction is 1 has no effect. Reading that level bit returns the synchronized pad value.
- R6: A 0-to-1 pad change sets the status bit when the rising arm is 1. A 1-to-0 change sets it when the falling arm is 1. With both arms set, either edge sets it.
- R7: No edge is detected on a pin whose enable is 0 or whose direction is 0.
- R8: A status bit stays set until a write of 1 to it. Writing 0 to it has no effect. If a new edge and a write-1 clear land in the same cycle, the bit stays set.
- R9: `event_out` is the OR over both banks of status AND event mask. It stays high while that condition holds.
- R10: The route register stores and returns its written value. It affects no other output.
- R11: After a pad change, the status bit is still clear following the second rising clock edge. It reads set following the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write enables |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS | Pad input values |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| event_out | output | 1 | Aggregate level event |

## Verification
If a status or mask bit is corrupted, it shows on `event_out` in the same cycle, and on a status read at once. A lost clear keeps the line high indefinitely. An edge detector with a wrong previous sample gives an extra or missing status bit three clock edges after the pad change. A wrong synchronizer depth moves that bit by a cycle, and the latency check catches this. A level or direction bit stored in the wrong bank shows on `pin_oe` and `pin_out` right after the write, and on the level readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned STRB_W = BUS_W / 8;

  typedef enum logic [2:0] {
    REG_ENABLE = 3'd0,
    REG_DIR    = 3'd1,
    REG_LEVEL  = 3'd2,
    REG_RISE   = 3'd3,
    REG_FALL   = 3'd4,
    REG_EVMASK = 3'd5,
    REG_ROUTE  = 3'd6,
    REG_STATUS = 3'd7
  } gpio_reg_e;

  function automatic logic [BUS_W-1:0] strb_to_mask(input logic [STRB_W-1:0] strb);
    logic [BUS_W-1:0] m;
    for (int k = 0; k < STRB_W; k++) begin
      m[8*k +: 8] = {8{strb[k]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q, stage2_q;
  logic stage1_d, stage2_d;

  always_comb begin
    stage1_d = 1'b1;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = pad_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sample_i,
  input  logic [WIDTH-1:0] arm_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  output logic [WIDTH-1:0] hit_o
);

  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] rose, fell;

  always_comb begin
    prev_d = sample_i;
    rose   = sample_i & ~prev_q;
    fell   = ~sample_i & prev_q;
    hit_o  = arm_i & ((rose & rise_en_i) | (fell & fall_en_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  gpio_reg_e         sel_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic [N-1:0]      pad_sync_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [N-1:0]      out_level_o,
  output logic [N-1:0]      out_en_o,
  output logic              event_o
);

  logic [BUS_W-1:0] full_mask;
  logic [N-1:0]     wmask, wd;

  logic [N-1:0] en_q, dir_q, lvl_q, rise_q, fall_q, evm_q, route_q, stat_q;
  logic [N-1:0] en_d, dir_d, lvl_d, rise_d, fall_d, evm_d, route_d, stat_d;
  logic         en_ce, dir_ce, lvl_ce, rise_ce, fall_ce, evm_ce, route_ce;
  logic [N-1:0] clr, hit, lvl_view;

  assign full_mask = strb_to_mask(wstrb_i);
  assign wmask     = full_mask[N-1:0];
  assign wd        = wdata_i[N-1:0];

  gpio_edge_detect #(.WIDTH(N)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (pad_sync_i),
    .arm_i     (en_q & dir_q),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .hit_o     (hit)
  );

  always_comb begin
    en_ce    = wr_i && (sel_i == REG_ENABLE);
    dir_ce   = wr_i && (sel_i == REG_DIR);
    lvl_ce   = wr_i && (sel_i == REG_LEVEL);
    rise_ce  = wr_i && (sel_i == REG_RISE);
    fall_ce  = wr_i && (sel_i == REG_FALL);
    evm_ce   = wr_i && (sel_i == REG_EVMASK);
    route_ce = wr_i && (sel_i == REG_ROUTE);

    en_d    = (en_q    & ~wmask) | (wd & wmask);
    dir_d   = (dir_q   & ~wmask) | (wd & wmask);
    rise_d  = (rise_q  & ~wmask) | (wd & wmask);
    fall_d  = (fall_q  & ~wmask) | (wd & wmask);
    evm_d   = (evm_q   & ~wmask) | (wd & wmask);
    route_d = (route_q & ~wmask) | (wd & wmask);
    // only output pins accept a new level
    lvl_d   = (lvl_q & ~(wmask & ~dir_q)) | (wd & wmask & ~dir_q);

    clr    = (wr_i && (sel_i == REG_STATUS)) ? (wd & wmask) : '0;
    stat_d = (stat_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      dir_q   <= '1;
      lvl_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      evm_q   <= '0;
      route_q <= '0;
      stat_q  <= '0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (dir_ce)   dir_q   <= dir_d;
      if (lvl_ce)   lvl_q   <= lvl_d;
      if (rise_ce)  rise_q  <= rise_d;
      if (fall_ce)  fall_q  <= fall_d;
      if (evm_ce)   evm_q   <= evm_d;
      if (route_ce) route_q <= route_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    lvl_view = (dir_q & pad_sync_i) | (~dir_q & lvl_q);
    rdata_o  = '0;
    unique case (sel_i)
      REG_ENABLE: rdata_o[N-1:0] = en_q;
      REG_DIR:    rdata_o[N-1:0] = dir_q;
      REG_LEVEL:  rdata_o[N-1:0] = lvl_view;
      REG_RISE:   rdata_o[N-1:0] = rise_q;
      REG_FALL:   rdata_o[N-1:0] = fall_q;
      REG_EVMASK: rdata_o[N-1:0] = evm_q;
      REG_ROUTE:  rdata_o[N-1:0] = route_q;
      REG_STATUS: rdata_o[N-1:0] = stat_q;
      default:    rdata_o        = '0;
    endcase
  end

  assign out_level_o = lvl_q;
  assign out_en_o    = en_q & ~dir_q;
  assign event_o     = |(stat_q & evm_q);

  // R8: a status bit with no clear request stays set
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr)));

  // R7: status only rises on pins that were enabled inputs
  a_r7_no_edge_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q & dir_q)) == '0));

  // R5: level bits of input pins never change
  a_r5_input_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0));

  // R3: bytes without a strobe keep their enable value
  a_r3_strobe_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((en_q ^ $past(en_q)) & ~$past(en_ce ? wmask : '0)) == '0));

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 14,
  parameter int unsigned RESUME_BASE = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic [STRB_W-1:0]   bus_wstrb,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                event_out
);

  localparam int unsigned LOW_N  = RESUME_BASE;
  localparam int unsigned HIGH_N = NUM_PINS - RESUME_BASE;

  logic                rst_int_n;
  logic [NUM_PINS-1:0] pad_sync;
  logic [BUS_W-1:0]    bank_rd [2];
  logic [1:0]          bank_evt;
  gpio_reg_e           sel;

  assign sel = gpio_reg_e'(bus_addr[4:2]);

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pad_i  (pin_in),
    .sync_o (pad_sync)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int unsigned BN = (b == 0) ? LOW_N : HIGH_N;
    localparam int unsigned BO = (b == 0) ? 0 : RESUME_BASE;

    gpio_bank #(.N(BN)) u_bank (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .wr_i        (bus_wr && (bus_addr[5] == 1'(b))),
      .sel_i       (sel),
      .wdata_i     (bus_wdata),
      .wstrb_i     (bus_wstrb),
      .pad_sync_i  (pad_sync[BO +: BN]),
      .rdata_o     (bank_rd[b]),
      .out_level_o (pin_out[BO +: BN]),
      .out_en_o    (pin_oe[BO +: BN]),
      .event_o     (bank_evt[b])
    );
  end

  assign bus_rdata = bank_rd[bus_addr[5]];
  assign event_out = |bank_evt;

  // R9: without a write, the aggregate event cannot drop
  a_r9_event_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (event_out && !bus_wr) |=> event_out);

endmodule

// File: tb/gpio_banked_ctrl_bench.sv
module gpio_banked_ctrl_bench;

  localparam int NP = 14;
  localparam int RB = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [5:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [3:0]    bus_wstrb;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          event_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_banked_ctrl #(.NUM_PINS(NP), .RESUME_BASE(RB)) u_gpio_banked_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .event_out(event_out)
  );

  localparam logic [5:0] LO = 6'h00, HI = 6'h20;
  localparam logic [5:0] O_EN = 6'h00, O_DIR = 6'h04, O_LVL = 6'h08, O_RISE = 6'h0C,
                         O_FALL = 6'h10, O_EVM = 6'h14, O_RT = 6'h18, O_ST = 6'h1C;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pad(input int p, input logic v);
    @(negedge clk);
    pin_in[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) begin
      logic [5:0] a = 6'(i * 4);
      logic [31:0] exp = 0;
      if ((i % 8) == 1) exp = (i < 8) ? 32'h3FF : 32'hF;
      rdchk("R1 reset register", a, exp);
    end
    chk("R1 reset oe", 32'(pin_oe), 0);
    chk("R1 reset event", 32'(event_out), 0);
  endtask

  task automatic t_strobe_route();
    wr(LO | O_RT, 32'hFFFF_FFFF, 4'b0001);
    rdchk("R3 low byte strobe", LO | O_RT, 32'h0FF);
    wr(LO | O_RT, 32'hFFFF_FFFF, 4'b0010);
    rdchk("R3 second byte strobe", LO | O_RT, 32'h3FF);
    wr(HI | O_RT, 32'h5, 4'hF);
    rdchk("R10 route stored", HI | O_RT, 32'h5);
    chk("R10 route no oe", 32'(pin_oe), 0);
    chk("R10 route no event", 32'(event_out), 0);
  endtask

  task automatic t_output();
    wr(LO | O_EN, 32'h3FF);
    wr(LO | O_DIR, 32'h3F7);
    wr(LO | O_LVL, 32'h008);
    chk("R4 pin3 out", 32'(pin_out[3]), 1);
    chk("R4 oe low bank", 32'(pin_oe), 32'h0008);
    rdchk("R5 level readback low", LO | O_LVL, 32'h008);
    wr(HI | O_EN, 32'hF);
    wr(HI | O_DIR, 32'hB);
    wr(HI | O_LVL, 32'h4);
    chk("R2 pin12 in high bank oe", 32'(pin_oe), 32'h1008);
    chk("R2 pin12 out", 32'(pin_out[12]), 1);
    rdchk("R2 high level read", HI | O_LVL, 32'h4);
  endtask

  task automatic t_level_ignored();
    wr(LO | O_LVL, 32'h028);
    rdchk("R5 input level write ignored", LO | O_LVL, 32'h008);
    pad(5, 1'b1);
    settle();
    rdchk("R5 input reads pad", LO | O_LVL, 32'h028);
    pad(5, 1'b0);
    settle();
    wr(LO | O_DIR, 32'h3D7);
    rdchk("R5 ignored write not stored", LO | O_LVL, 32'h008);
    chk("R5 pin5 drives 0", 32'(pin_out[5]), 0);
    wr(LO | O_DIR, 32'h3FF);
    wr(HI | O_DIR, 32'hF);
    chk("R4 all inputs oe", 32'(pin_oe), 0);
  endtask

  task automatic t_edges();
    wr(LO | O_RISE, 32'h005);
    wr(LO | O_FALL, 32'h006);
    pad(0, 1'b1);
    @(posedge clk); @(posedge clk);
    rdchk("R11 not yet after two edges", LO | O_ST, 32'h000);
    rdchk("R11 set after third edge", LO | O_ST, 32'h001);
    pad(1, 1'b1); settle();
    rdchk("R6 rise on fall-only pin ignored", LO | O_ST, 32'h001);
    pad(1, 1'b0); settle();
    rdchk("R6 fall detected", LO | O_ST, 32'h003);
    pad(2, 1'b1); settle();
    rdchk("R6 both arms rise", LO | O_ST, 32'h007);
    wr(LO | O_ST, 32'h7);
    rdchk("R8 clear all", LO | O_ST, 32'h000);
    pad(2, 1'b0); settle();
    rdchk("R6 both arms fall", LO | O_ST, 32'h004);
    pad(0, 1'b0); settle();
    rdchk("R6 fall on rise-only pin ignored", LO | O_ST, 32'h004);
  endtask

  task automatic t_sticky();
    wr(LO | O_ST, 32'h000);
    rdchk("R8 write zero no effect", LO | O_ST, 32'h004);
    repeat (10) @(posedge clk);
    rdchk("R8 stays set", LO | O_ST, 32'h004);
    wr(LO | O_ST, 32'h004);
    rdchk("R8 write one clears", LO | O_ST, 32'h000);
    pad(0, 1'b1); settle();
    rdchk("R8 bit set again", LO | O_ST, 32'h001);
    pad(0, 1'b0); settle();
    pad(0, 1'b1);
    @(posedge clk); @(posedge clk);
    wr(LO | O_ST, 32'h001);
    rdchk("R8 set wins over clear", LO | O_ST, 32'h001);
    wr(LO | O_ST, 32'h001);
    rdchk("R8 clear after collision", LO | O_ST, 32'h000);
  endtask

  task automatic t_disabled();
    wr(LO | O_EN, 32'h3EF);
    wr(LO | O_RISE, 32'h055);
    wr(LO | O_DIR, 32'h3BF);
    pad(4, 1'b1);
    pad(6, 1'b1);
    settle();
    rdchk("R7 disabled and output pins no edge", LO | O_ST, 32'h000);
    pad(4, 1'b0);
    pad(6, 1'b0);
    settle();
    wr(LO | O_EN, 32'h3FF);
    wr(LO | O_DIR, 32'h3FF);
    rdchk("R7 still clear", LO | O_ST, 32'h000);
  endtask

  task automatic t_event();
    wr(HI | O_RISE, 32'h2);
    pad(11, 1'b1); settle();
    rdchk("R2 pin11 status in high bank bit1", HI | O_ST, 32'h2);
    chk("R9 masked no event", 32'(event_out), 0);
    wr(HI | O_EVM, 32'h2);
    chk("R9 event raised", 32'(event_out), 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9 event level held", 32'(event_out), 1);
    wr(HI | O_EVM, 32'h0);
    chk("R9 mask drops event", 32'(event_out), 0);
    wr(HI | O_EVM, 32'h2);
    chk("R9 unmask raises event", 32'(event_out), 1);
    wr(HI | O_ST, 32'h2);
    chk("R9 clear drops event", 32'(event_out), 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wstrb = '0;
    pin_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_strobe_route();
    t_output();
    t_level_ignored();
    t_edges();
    t_sticky();
    t_disabled();
    t_event();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule